// File: doc/BRIEF.md
# Latched Planar Read Datapath

This block produces the byte returned to a processor that reads a planar display memory. The memory is organised as four planes that sit side by side in one 32-bit word, one byte per plane. Every read strobe captures that whole word in a 32-bit latch. The latch is an output because the write path uses it as its source of old plane data.

The returned byte comes from one of two modes. In plane mode the block returns the byte of one plane, chosen by a select input. In colour-compare mode each of the eight bit positions stands for one pixel. The pixel's four plane bits are compared against a 4-bit reference colour. A don't-care mask removes planes from the comparison. The returned bit is 1 when every plane that takes part matches.

The result is registered. It appears on the clock edge at which the strobe is sampled and holds until the next strobe.

Top module: `plane_latch_reader`

## Requirements
- R1: After reset, `latch_q` is 0 and `rd_data` is 0.
- R2: When `rd_stb` is sampled high at a clock edge, `latch_q` takes the value of `mem_word` at that same edge. Plane k occupies bits [8k+7:8k].
- R3: While `rd_stb` is low, `latch_q` and `rd_data` keep their values, whatever the other inputs do.
- R4: When `cmp_mode` is 0, `rd_data` becomes the byte of plane `plane_sel`, taken from the word fetched by the strobe.
- R5: Only bits [1:0] of `plane_sel` choose the plane. Bits [3:2] have no effect.
- R6: When `cmp_mode` is 1, bit i of `rd_data` is 1 if and only if bit i of the byte of plane p equals `ref_color[p]` for every plane p with `care_mask[p]` = 1.
- R7: When `cmp_mode` is 1 and `care_mask` is 0, `rd_data` is 8'hFF.
- R8: `rd_data` is registered. It is valid from the clock edge that samples `rd_stb`. It is computed from the newly fetched word, not from the earlier contents of the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | Planar read strobe |
| mem_word | input | 32 | Memory word at the read address, four plane bytes |
| cmp_mode | input | 1 | 0: plane byte, 1: colour compare |
| plane_sel | input | 4 | Plane to return in plane mode (low 2 bits used) |
| ref_color | input | 4 | Reference colour, one bit per plane |
| care_mask | input | 4 | Planes taking part in the compare |
| rd_data | output | 8 | Registered read result |
| latch_q | output | 32 | Latched memory word, shared with the write path |

## Verification
A wrong latch appears on `latch_q` one edge after the strobe. If the latch loaded too little or held too little, a read that follows it with no strobe in between exposes the error on the same port. A wrong lane order or a faulty compare shows on `rd_data` at the first edge after the strobe. That edge is also where a design that uses the old latch instead of the fresh word would return the previous read's answer. Back-to-back reads with different words separate these two cases.

// File: rtl/plr_pkg.sv
package plr_pkg;
   localparam int unsigned PLR_PLANES_DEF = 4;
   localparam int unsigned PLR_LANE_W_DEF = 8;
   localparam int unsigned PLR_SEL_W_DEF  = 4;

   typedef enum logic {
      PLR_MODE_PLANE   = 1'b0,
      PLR_MODE_COMPARE = 1'b1
   } plr_mode_e;
endpackage

// File: rtl/plr_expand.sv
module plr_expand #(
   parameter int unsigned PLANES = 4,
   parameter int unsigned LANE_W = 8
) (
   input  logic [PLANES-1:0]        bits_i,
   output logic [PLANES*LANE_W-1:0] mask_o
);
   for (genvar p = 0; p < PLANES; p++) begin : g_lane
      assign mask_o[p*LANE_W +: LANE_W] = {LANE_W{bits_i[p]}};
   end
endmodule

// File: rtl/plr_sel.sv
module plr_sel #(
   parameter int unsigned PLANES = 4,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned IDX_W = (PLANES > 1) ? $clog2(PLANES) : 1
) (
   input  logic [PLANES*LANE_W-1:0] word_i,
   input  logic [IDX_W-1:0]         idx_i,
   output logic [LANE_W-1:0]        byte_o
);
   logic [LANE_W-1:0] lanes [PLANES];

   for (genvar p = 0; p < PLANES; p++) begin : g_split
      assign lanes[p] = word_i[p*LANE_W +: LANE_W];
   end

   always_comb begin
      byte_o = '0;
      for (int p = 0; p < PLANES; p++) begin
         if (idx_i == IDX_W'(p)) byte_o = lanes[p];
      end
   end
endmodule

// File: rtl/plr_cmp.sv
module plr_cmp #(
   parameter int unsigned PLANES = 4,
   parameter int unsigned LANE_W = 8
) (
   input  logic [PLANES*LANE_W-1:0] word_i,
   input  logic [PLANES-1:0]        ref_i,
   input  logic [PLANES-1:0]        care_i,
   output logic [LANE_W-1:0]        match_o
);
   localparam int unsigned WORD_W = PLANES * LANE_W;

   logic [WORD_W-1:0] ref_mask;
   logic [WORD_W-1:0] care_mask;
   logic [WORD_W-1:0] diff;
   logic [LANE_W-1:0] acc [PLANES+1];

   plr_expand #(.PLANES(PLANES), .LANE_W(LANE_W)) u_ref_exp (
      .bits_i (ref_i),
      .mask_o (ref_mask)
   );

   plr_expand #(.PLANES(PLANES), .LANE_W(LANE_W)) u_care_exp (
      .bits_i (care_i),
      .mask_o (care_mask)
   );

   assign diff   = (word_i ^ ref_mask) & care_mask;
   assign acc[0] = '0;

   for (genvar p = 0; p < PLANES; p++) begin : g_fold
      assign acc[p+1] = acc[p] | diff[p*LANE_W +: LANE_W];
   end

   assign match_o = ~acc[PLANES];

   // R7
   always_comb begin
      care_none_chk: assert (care_i != '0 || match_o == {LANE_W{1'b1}})
         else $error("compare with empty care mask did not give all ones");
   end
endmodule

// File: rtl/plane_latch_reader.sv
module plane_latch_reader
   import plr_pkg::*;
#(
   parameter int unsigned PLANES = PLR_PLANES_DEF,
   parameter int unsigned LANE_W = PLR_LANE_W_DEF,
   parameter int unsigned SEL_W  = PLR_SEL_W_DEF,
   localparam int unsigned WORD_W = PLANES * LANE_W,
   localparam int unsigned IDX_W  = (PLANES > 1) ? $clog2(PLANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic [WORD_W-1:0] mem_word,
   input  logic              cmp_mode,
   input  logic [SEL_W-1:0]  plane_sel,
   input  logic [PLANES-1:0] ref_color,
   input  logic [PLANES-1:0] care_mask,
   output logic [LANE_W-1:0] rd_data,
   output logic [WORD_W-1:0] latch_q
);
   if (PLANES < 2 || (1 << IDX_W) != PLANES) begin : g_bad_planes
      $error("PLANES must be a power of two of at least 2");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("LANE_W must be at least 1");
   end
   if (SEL_W < IDX_W) begin : g_bad_sel
      $error("SEL_W too narrow for PLANES");
   end

   logic [LANE_W-1:0] plane_byte;
   logic [LANE_W-1:0] cmp_byte;
   logic [LANE_W-1:0] next_data;
   plr_mode_e         mode;

   assign mode = plr_mode_e'(cmp_mode);

   plr_sel #(.PLANES(PLANES), .LANE_W(LANE_W)) u_sel (
      .word_i (mem_word),
      .idx_i  (plane_sel[IDX_W-1:0]),
      .byte_o (plane_byte)
   );

   plr_cmp #(.PLANES(PLANES), .LANE_W(LANE_W)) u_cmp (
      .word_i  (mem_word),
      .ref_i   (ref_color),
      .care_i  (care_mask),
      .match_o (cmp_byte)
   );

   assign next_data = (mode == PLR_MODE_COMPARE) ? cmp_byte : plane_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         rd_data <= '0;
      end else if (rd_stb) begin
         latch_q <= mem_word;
         rd_data <= next_data;
      end
   end

   // R2
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> latch_q == $past(mem_word))
      else $error("latch did not load the fetched word");

   // R3
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(latch_q))
      else $error("latch changed without a read");

   // R3
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data))
      else $error("read data changed without a read");

   // R7
   care_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && cmp_mode && care_mask == '0) |=> rd_data == {LANE_W{1'b1}})
      else $error("empty care mask read did not return all ones");

   // R4
   plane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !cmp_mode && plane_sel[IDX_W-1:0] == '0) |=> rd_data == latch_q[LANE_W-1:0])
      else $error("plane 0 read does not match latch lane 0");
endmodule

// File: tb/plane_latch_reader_bench.sv
module plane_latch_reader_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_stb = 1'b0;
   logic [31:0] mem_word = '0;
   logic        cmp_mode = 1'b0;
   logic [3:0]  plane_sel = '0;
   logic [3:0]  ref_color = '0;
   logic [3:0]  care_mask = '0;
   logic [7:0]  rd_data;
   logic [31:0] latch_q;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   plane_latch_reader u_plane_latch_reader (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_stb    (rd_stb),
      .mem_word  (mem_word),
      .cmp_mode  (cmp_mode),
      .plane_sel (plane_sel),
      .ref_color (ref_color),
      .care_mask (care_mask),
      .rd_data   (rd_data),
      .latch_q   (latch_q)
   );

   function automatic logic [7:0] exp_byte(input logic [31:0] w, input logic mode,
                                           input logic [3:0] sel, input logic [3:0] rc,
                                           input logic [3:0] cm);
      logic [7:0] r;
      if (!mode) begin
         r = w[8*sel[1:0] +: 8];
      end else begin
         for (int i = 0; i < 8; i++) begin
            r[i] = 1'b1;
            for (int p = 0; p < 4; p++)
               if (cm[p] && (w[8*p+i] != rc[p])) r[i] = 1'b0;
         end
      end
      return r;
   endfunction

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s rd_data act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s latch_q act=%h exp=%h", req, act, exp);
      end
   endtask

   // one strobe at a negedge; results sampled at the following negedge
   task automatic do_read(input logic [31:0] w, input logic mode, input logic [3:0] sel,
                          input logic [3:0] rc, input logic [3:0] cm);
      @(negedge clk);
      mem_word = w; cmp_mode = mode; plane_sel = sel; ref_color = rc; care_mask = cm;
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic t_reset;
      check32("R1", latch_q, 32'h0);
      check8("R1", rd_data, 8'h00);
   endtask

   task automatic t_plane_bytes;
      logic [31:0] w = 32'hA1B2C3D4;
      for (int p = 0; p < 4; p++) begin
         do_read(w, 1'b0, 4'(p), 4'h0, 4'h0);
         check8("R4", rd_data, exp_byte(w, 1'b0, 4'(p), 4'h0, 4'h0));
         check32("R2", latch_q, w);
      end
   endtask

   task automatic t_sel_upper;
      logic [31:0] w = 32'h11223344;
      do_read(w, 1'b0, 4'b1110, 4'h0, 4'h0);
      check8("R5", rd_data, 8'h22);
      do_read(w, 1'b0, 4'b0111, 4'h0, 4'h0);
      check8("R5", rd_data, 8'h11);
   endtask

   task automatic t_compare;
      logic [31:0] w = 32'hF0F0F0F0;
      do_read(w, 1'b1, 4'h0, 4'hF, 4'hF);
      check8("R6", rd_data, 8'hF0);
      do_read(w, 1'b1, 4'h0, 4'h0, 4'hF);
      check8("R6", rd_data, 8'h0F);
      w = 32'h0FF0_33CC;
      do_read(w, 1'b1, 4'h0, 4'b0101, 4'b0111);
      check8("R6", rd_data, exp_byte(w, 1'b1, 4'h0, 4'b0101, 4'b0111));
      do_read(w, 1'b1, 4'h0, 4'b1010, 4'b1000);
      check8("R6", rd_data, 8'h0F);
      check32("R2", latch_q, w);
   endtask

   task automatic t_care_none;
      do_read(32'h5A3C9612, 1'b1, 4'h0, 4'h7, 4'h0);
      check8("R7", rd_data, 8'hFF);
   endtask

   task automatic t_hold;
      logic [7:0]  d0;
      logic [31:0] l0;
      do_read(32'hDEADBEEF, 1'b0, 4'h1, 4'h0, 4'h0);
      d0 = rd_data; l0 = latch_q;
      check8("R4", d0, 8'hBE);
      mem_word = 32'h01234567; cmp_mode = 1'b1; care_mask = 4'h0; plane_sel = 4'h3;
      repeat (3) @(negedge clk);
      check8("R3", rd_data, d0);
      check32("R3", latch_q, l0);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      mem_word = 32'h00000011; cmp_mode = 1'b0; plane_sel = 4'h0; rd_stb = 1'b1;
      @(negedge clk);
      check8("R8", rd_data, 8'h11);
      mem_word = 32'h00000022;
      @(negedge clk);
      rd_stb = 1'b0;
      check8("R8", rd_data, 8'h22);
      check32("R2", latch_q, 32'h00000022);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plane_bytes();
      t_sel_upper();
      t_compare();
      t_care_none();
      t_hold();
      t_back_to_back();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule